// File: doc/BRIEF.md
# Watchdog Second-Expiry Status and Recovery Register

This block holds the status word that a platform watchdog leaves behind when it has run out a second time. Sticky flags record a second watchdog expiry, a chassis intrusion, and an SMI message that arrives on a sideband slave link. A fourth flag marks a second expiry that happened before the processor had fetched its first instruction, which points to a boot that never started. Software reads the word over a simple register port and clears a flag by writing 1 to its bit.

When the second-expiry flag rises and reboots are permitted, the block issues a fixed-length platform reset request. If the boot-failure flag is also set while that request is active, the block overrides the processor clock-multiplier selection with the safe value, so that the next boot can come up from a bad multiplier setting. The intrusion flag belongs to an always-on domain and has its own reset. The other flags use the resume-domain reset.

The watchdog counter, the interrupt routing and the processor are outside the block. The block sees them as an expiry pulse, event pulses and a fetched-first-instruction level.

Top module: `wdt_sto_status`

## Requirements
- R1: After either reset the register reads 0000h and the reset request is low. Bits 15:5 and bit 3 always read 0, and writes to them have no effect.
- R2: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Writes take effect only when the register is selected.
- R3: When a hardware set event and a write-one-to-clear reach the same bit in the same cycle, the bit ends up set.
- R4: A pulse on the watchdog expiry input sets the second-expiry bit (bit 1) on the next clock edge.
- R5: The boot-failure bit (bit 2) sets when bit 1 goes from 0 to 1 while the fetched-first-instruction input is low. It does not set when that input is high.
- R6: A write of 1 to bit 2 clears it only if bit 1 is already 0 before the write. Clearing both bits in one write clears only bit 1.
- R7: Each 0-to-1 change of bit 1 with the no-reboot input low raises the platform reset request for exactly PULSE_CYC (default 16) cycles, starting in the cycle in which bit 1 reads 1. An expiry while bit 1 is already set starts no new request. No request is made while no-reboot is high.
- R8: While the reset request is high and bit 2 is set, the multiplier output is 4'b1111. Otherwise the multiplier output equals the configured multiplier input.
- R9: The intrusion bit (bit 0) sets on an intrusion pulse. Only the always-on reset or a write of 1 clears it; the resume reset leaves it unchanged.
- R10: The sideband SMI bit (bit 4) sets on a sideband SMI message pulse. The resume reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_resume_n | input | 1 | Resume-domain reset, active low; clears bits 1, 2, 4 and the reset request |
| rst_rtc_n | input | 1 | Always-on-domain reset, active low; clears bit 0 |
| reg_sel_i | input | 1 | Register selected on the bus |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | REG_W | Write data, 1 clears the matching bit |
| reg_rdata_o | output | REG_W | Current register value |
| wdt_expire_i | input | 1 | Second watchdog expiry pulse |
| intrude_i | input | 1 | Chassis intrusion pulse |
| sideband_smi_i | input | 1 | Sideband slave SMI message pulse |
| cpu_fetched_i | input | 1 | Processor has fetched its first instruction |
| no_reboot_i | input | 1 | Suppress the reboot request |
| cfg_mult_i | input | MULT_W | Configured processor multiplier |
| plat_reset_o | output | 1 | Platform reset request |
| cpu_mult_o | output | MULT_W | Multiplier to the processor |

## Verification
Each status flag appears directly in the read word, so a wrongly set or wrongly cleared flag shows up on the next read after the clock edge that changed it. A bad boot-failure flag or pulse counter shows up at the reset and multiplier outputs. The request length is off by some number of cycles, a request comes when none should, or the multiplier is wrong in the first cycle of the request. A reset that clears the wrong domain shows up on the first read after that reset is released.

// File: rtl/wdt_sto_pkg.sv
package wdt_sto_pkg;
    localparam int REG_W        = 16;
    localparam int BIT_INTRUDE  = 0;
    localparam int BIT_SECOND   = 1;
    localparam int BIT_BOOTFAIL = 2;
    localparam int BIT_SIDEBAND = 4;
    // resume-domain flags handled by a generate loop, index order below
    localparam int NUM_RES      = 3;
    localparam int RES_SECOND   = 0;
    localparam int RES_BOOTFAIL = 1;
    localparam int RES_SIDEBAND = 2;
endpackage

// File: rtl/wdt_sticky_bit.sv
module wdt_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o)); // R2
endmodule

// File: rtl/wdt_reboot_pulse.sv
module wdt_reboot_pulse #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic req_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt = CW'(PULSE_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = (st_q.cnt != '0);

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> req_o); // R7
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !req_o) |=> !req_o); // R7
endmodule

// File: rtl/wdt_sto_status.sv
module wdt_sto_status
    import wdt_sto_pkg::*;
#(
    parameter int                 MULT_W    = 4,
    parameter logic [MULT_W-1:0]  SAFE_MULT = '1,
    parameter int                 PULSE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_resume_n,
    input  logic              rst_rtc_n,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              wdt_expire_i,
    input  logic              intrude_i,
    input  logic              sideband_smi_i,
    input  logic              cpu_fetched_i,
    input  logic              no_reboot_i,
    input  logic [MULT_W-1:0] cfg_mult_i,
    output logic              plat_reset_o,
    output logic [MULT_W-1:0] cpu_mult_o
);
    logic               wr_hit;
    logic [NUM_RES-1:0] res_set;
    logic [NUM_RES-1:0] res_clr;
    logic [NUM_RES-1:0] res_q;
    logic               intr_q;
    logic               second_q;
    logic               boot_q;
    logic               second_rise;
    logic               pulse_start;

    assign wr_hit      = reg_sel_i & reg_wr_i;
    assign second_q    = res_q[RES_SECOND];
    assign boot_q      = res_q[RES_BOOTFAIL];
    assign second_rise = wdt_expire_i & ~second_q;
    assign pulse_start = second_rise & ~no_reboot_i;

    always_comb begin
        res_set = '0;
        res_clr = '0;
        res_set[RES_SECOND]   = wdt_expire_i;
        res_set[RES_BOOTFAIL] = second_rise & ~cpu_fetched_i;
        res_set[RES_SIDEBAND] = sideband_smi_i;
        res_clr[RES_SECOND]   = wr_hit & reg_wdata_i[BIT_SECOND];
        // boot flag clear needs second-expiry flag already low
        res_clr[RES_BOOTFAIL] = wr_hit & reg_wdata_i[BIT_BOOTFAIL] & ~second_q;
        res_clr[RES_SIDEBAND] = wr_hit & reg_wdata_i[BIT_SIDEBAND];
    end

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        wdt_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_resume_n),
            .set_i (res_set[g]),
            .clr_i (res_clr[g]),
            .q_o   (res_q[g])
        );
    end

    wdt_sticky_bit u_intr (
        .clk   (clk),
        .rst_n (rst_rtc_n),
        .set_i (intrude_i),
        .clr_i (wr_hit & reg_wdata_i[BIT_INTRUDE]),
        .q_o   (intr_q)
    );

    wdt_reboot_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_resume_n),
        .start_i (pulse_start),
        .req_o   (plat_reset_o)
    );

    always_comb begin
        reg_rdata_o               = '0;
        reg_rdata_o[BIT_INTRUDE]  = intr_q;
        reg_rdata_o[BIT_SECOND]   = second_q;
        reg_rdata_o[BIT_BOOTFAIL] = boot_q;
        reg_rdata_o[BIT_SIDEBAND] = res_q[RES_SIDEBAND];
    end

    assign cpu_mult_o = (plat_reset_o && boot_q) ? SAFE_MULT : cfg_mult_i;

    AST_BOOT_NEEDS_SECOND: assert property (@(posedge clk) disable iff (!rst_resume_n)
        $rose(boot_q) |-> second_q); // R5
    AST_BOOT_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_resume_n)
        (second_q && boot_q) |=> boot_q); // R6
    AST_PULSE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_resume_n)
        $rose(plat_reset_o) |-> $rose(second_q)); // R7
    AST_SAFE_MULT: assert property (@(posedge clk) disable iff (!rst_resume_n)
        (plat_reset_o && boot_q) |-> (cpu_mult_o == SAFE_MULT)); // R8
endmodule

// File: tb/sim_wdt_sto_status.sv
module sim_wdt_sto_status;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic        clk = 1'b0;
    logic        rst_resume_n = 1'b0;
    logic        rst_rtc_n = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        wdt_expire_i = 1'b0;
    logic        intrude_i = 1'b0;
    logic        sideband_smi_i = 1'b0;
    logic        cpu_fetched_i = 1'b1;
    logic        no_reboot_i = 1'b1;
    logic [3:0]  cfg_mult_i = 4'h5;
    logic        plat_reset_o;
    logic [3:0]  cpu_mult_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_sto_status u0 (
        .clk(clk), .rst_resume_n(rst_resume_n), .rst_rtc_n(rst_rtc_n),
        .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .wdt_expire_i(wdt_expire_i), .intrude_i(intrude_i),
        .sideband_smi_i(sideband_smi_i), .cpu_fetched_i(cpu_fetched_i),
        .no_reboot_i(no_reboot_i), .cfg_mult_i(cfg_mult_i),
        .plat_reset_o(plat_reset_o), .cpu_mult_o(cpu_mult_o)
    );

    // {wr, wdata[15:0], expire, intrude, sideband, fetched, expected[15:0]}
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0002}, // R4
        {1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0002}, // R2 write 0
        {1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0003}, // R9
        {1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0013}, // R10
        {1'b1, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0011}, // R2
        {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0017}, // R5
        {1'b1, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0017}, // R6
        {1'b1, 16'h0006, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0015}, // R6
        {1'b1, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0011}, // R6
        {1'b1, 16'hFFE8, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0011}, // R1 reserved
        {1'b1, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0011}, // R3
        {1'b1, 16'h0011, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000}, // R2
        {1'b1, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0006}, // R3 R5
        {1'b1, 16'h0006, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0004}, // R6
        {1'b1, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000}  // R6
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        reg_sel_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        wdt_expire_i = 1'b0; intrude_i = 1'b0; sideband_smi_i = 1'b0;
        cpu_fetched_i = 1'b1;
    endtask

    task automatic write_reg(input logic [15:0] d);
        @(negedge clk);
        reg_sel_i = 1'b1; reg_wr_i = 1'b1; reg_wdata_i = d;
        @(negedge clk);
        go_idle();
    endtask

    // counts request cycles and multiplier mismatches over a window
    task automatic watch(input int cycles, input logic [3:0] mult_exp,
                         output int req_cnt, output int mult_bad);
        req_cnt = 0; mult_bad = 0;
        for (int k = 0; k < cycles; k++) begin
            if (plat_reset_o) begin
                req_cnt++;
                if (cpu_mult_o !== mult_exp) mult_bad++;
            end
            @(negedge clk);
        end
    endtask

    task automatic expire(input logic fetched);
        @(negedge clk);
        wdt_expire_i = 1'b1; cpu_fetched_i = fetched;
        @(negedge clk);
        go_idle();
    endtask

    initial begin
        int rc, mb;
        repeat (3) @(negedge clk);
        rst_resume_n = 1'b1; rst_rtc_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", reg_rdata_o, 16'h0000);
        check("R1 no request", {15'b0, plat_reset_o}, 16'h0000);
        check("R8 passthrough", {12'b0, cpu_mult_o}, 16'h0005);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            reg_sel_i = VEC[i][36]; reg_wr_i = VEC[i][36];
            reg_wdata_i = VEC[i][35:20];
            wdt_expire_i = VEC[i][19]; intrude_i = VEC[i][18];
            sideband_smi_i = VEC[i][17]; cpu_fetched_i = VEC[i][16];
            @(negedge clk);
            go_idle();
            check($sformatf("vector %0d R1-R10 table", i), reg_rdata_o, VEC[i][15:0]);
        end

        // pulse without boot failure: multiplier stays configured
        no_reboot_i = 1'b0;
        expire(1'b1);
        watch(20, 4'h5, rc, mb);
        check("R7 pulse length", 16'(rc), 16'd16);
        check("R8 no override", 16'(mb), 16'd0);
        // expiry while flag still set: no new request
        expire(1'b1);
        watch(20, 4'h5, rc, mb);
        check("R7 one per edge", 16'(rc), 16'd0);
        write_reg(16'h0002);
        check("R2 cleared", reg_rdata_o, 16'h0000);

        // pulse with boot failure: safe multiplier
        expire(1'b0);
        check("R5 boot set", reg_rdata_o, 16'h0006);
        watch(20, 4'hF, rc, mb);
        check("R7 pulse length boot", 16'(rc), 16'd16);
        check("R8 safe multiplier", 16'(mb), 16'd0);
        check("R8 released after pulse", {12'b0, cpu_mult_o}, 16'h0005);
        write_reg(16'h0006);
        write_reg(16'h0004);
        check("R6 both cleared", reg_rdata_o, 16'h0000);

        // reboot suppressed
        no_reboot_i = 1'b1;
        expire(1'b1);
        check("R4 set with no-reboot", reg_rdata_o, 16'h0002);
        watch(20, 4'h5, rc, mb);
        check("R7 suppressed", 16'(rc), 16'd0);
        write_reg(16'h0002);

        // reset domains
        @(negedge clk);
        intrude_i = 1'b1; sideband_smi_i = 1'b1; wdt_expire_i = 1'b1;
        @(negedge clk);
        go_idle();
        check("R9 R10 all set", reg_rdata_o, 16'h0013);
        rst_resume_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_resume_n = 1'b1;
        @(negedge clk);
        check("R9 R10 resume reset", reg_rdata_o, 16'h0001);
        rst_rtc_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_rtc_n = 1'b1;
        @(negedge clk);
        check("R9 rtc reset", reg_rdata_o, 16'h0000);

        // reset in the middle of a request
        no_reboot_i = 1'b0;
        expire(1'b1);
        repeat (3) @(negedge clk);
        rst_resume_n = 1'b0;
        @(negedge clk);
        check("R1 request dropped", {15'b0, plat_reset_o}, 16'h0000);
        rst_resume_n = 1'b1;
        @(negedge clk);
        check("R1 reset after pulse", reg_rdata_o, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired R1 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule